// File: doc/BRIEF.md
# Packed half-precision to unsigned 16-bit integer converter

This block takes a vector of half-precision floating-point lanes and turns each lane into a 16-bit unsigned integer. The result lands in the 16-bit slot the lane came from. A two-bit length code sets the active vector to a quarter, a half or all of the maximum width. The default maximum width is 512 bits, which gives 8, 16 or 32 lanes.

Per operation the caller supplies several controls:
- Two rounding-mode fields. The embedded one takes effect only for a full-width register source with the override bit set. In every other case the global field is used.
- A source-is-memory flag. Together with the override bit it broadcasts element 0 to every lane.
- A per-lane writemask with an enable bit.
- A zeroing-mode bit.
- The old destination vector, which merge masking needs.

Out-of-range and non-numeric inputs return the all-ones indefinite value. Two sticky flags record an invalid conversion and an inexact conversion. They are cleared only by reset.

The parameter `REG_OUT` selects the timing. When it is 1 (the default), the destination and its valid bit appear one clock after the request. When it is 0, they appear in the same cycle. In both cases the flags are updated at the clock edge that follows the request.

Top module: `pf16_u16_cvt`

## Requirements
- R1: Lane j occupies bits 16j+15..16j of both source and destination. The length code `vlen_sel` gives 8 lanes for 2'b00, 16 lanes for 2'b01 and 32 lanes for 2'b10 or 2'b11 (default width).
- R2: A lane value that is not exact is rounded by the selected two-bit mode. The encodings are 2'b00 nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. Subnormal inputs therefore give 0 or 1.
- R3: The rounding mode is taken from `rc_embedded` only when `src_is_mem` is 0, `vlen_sel[1]` is 1 and `bcst_rc` is 1. In all other cases it comes from `rc_global`.
- R4: When `src_is_mem` and `bcst_rc` are both 1, every lane converts source bits 15..0 instead of its own element.
- R5: With `mask_en` at 0 every active lane is converted. With `mask_en` at 1, only lanes whose `lane_mask` bit is 1 are converted.
- R6: An active lane that is not converted is written with 0 when `zero_mode` is 1. Otherwise it keeps its `old_dst` value.
- R7: Every destination bit at or above the active length is 0.
- R8: The lane returns 16'hFFFF and sets `flag_invalid` in these cases:
  - the exponent field (bits 14..10) is all ones, meaning a NaN or an infinity;
  - the rounded value is negative and non-zero;
  - the rounded value exceeds 65535.
- R9: An inexact conversion that is valid sets `flag_inexact`. A negative input that rounds to zero gives 0 and also sets `flag_inexact`. An invalid lane does not set `flag_inexact`.
- R10: Only converted lanes contribute to the flags. Both flags are sticky: once set, they stay high until reset.
- R11: With `REG_OUT`=1, `out_valid` and `dst_vec` update at the first rising edge after a cycle with `in_valid` high. After an idle cycle, `out_valid` is low and `dst_vec` holds its value.
- R12: Reset clears `dst_vec`, `out_valid`, `flag_invalid` and `flag_inexact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| vlen_sel | input | 2 | Active length code |
| src_vec | input | DW (512) | Half-precision source lanes |
| src_is_mem | input | 1 | Source comes from memory |
| bcst_rc | input | 1 | Broadcast / rounding-override bit |
| rc_embedded | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| lane_mask | input | MAX_LANES (32) | Per-lane write enables |
| mask_en | input | 1 | Writemask in use |
| zero_mode | input | 1 | Zero (1) or merge (0) unselected lanes |
| old_dst | input | DW (512) | Previous destination value |
| out_valid | output | 1 | Result valid |
| dst_vec | output | DW (512) | Converted destination vector |
| flag_invalid | output | 1 | Sticky invalid-conversion flag |
| flag_inexact | output | 1 | Sticky inexact-conversion flag |

## Verification
With the default `REG_OUT`=1, the destination and `out_valid` are due at the first rising edge after the request. The sticky flags update at that same edge. The bench drives each request on a falling edge and compares the destination and both flags at the next falling edge, half a cycle after they settle. It keeps its own running OR of the expected flags so that stickiness is checked on every operation. The idle check samples one falling edge after an idle cycle, when `out_valid` must already be low.

// File: rtl/pf16cvt_pkg.sv
package pf16cvt_pkg;

  localparam int HW = 16;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'b00,
    RND_DOWN  = 2'b01,
    RND_UP    = 2'b10,
    RND_TRUNC = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic [HW-1:0] val;
    logic          inv;
    logic          inx;
  } cvt_res_t;

  // Half-precision value to unsigned 16-bit integer under a rounding mode.
  function automatic cvt_res_t fp16_to_u16(input logic [HW-1:0] h, input rnd_mode_e rm);
    cvt_res_t    res;
    logic        s;
    logic [4:0]  e;
    logic [9:0]  m;
    logic [10:0] sig;
    logic [4:0]  rsh;
    logic [34:0] wide;
    logic [10:0] q;
    logic [23:0] frac;
    logic        up;
    logic [16:0] mag;
    logic [15:0] ipart;
    res  = '0;
    s    = h[15];
    e    = h[14:10];
    m    = h[9:0];
    sig  = {(e != 5'd0), m};
    rsh  = '0;
    wide = '0;
    q    = '0;
    frac = '0;
    up   = 1'b0;
    mag  = '0;
    ipart = '0;
    if (e == 5'h1f) begin
      res.val = 16'hFFFF;
      res.inv = 1'b1;
    end else if (e == 5'd0 && m == 10'd0) begin
      res.val = '0;
    end else if (e >= 5'd25) begin
      // integer value, exact; largest finite magnitude fits in 16 bits
      ipart = {5'd0, sig} << (e - 5'd25);
      if (s) begin
        res.val = 16'hFFFF;
        res.inv = 1'b1;
      end else begin
        res.val = ipart;
      end
    end else begin
      rsh  = (e == 5'd0) ? 5'd24 : (5'd25 - e);
      wide = {sig, 24'd0} >> rsh;
      q    = wide[34:24];
      frac = wide[23:0];
      unique case (rm)
        RND_NEAR:  up = frac[23] & ((|frac[22:0]) | q[0]);
        RND_DOWN:  up = s & (|frac);
        RND_UP:    up = ~s & (|frac);
        default:   up = 1'b0;
      endcase
      mag = {6'd0, q} + {16'd0, up};
      if ((s && mag != 17'd0) || mag[16]) begin
        res.val = 16'hFFFF;
        res.inv = 1'b1;
      end else begin
        res.val = mag[15:0];
        res.inx = |frac;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/pf16_ctl.sv
module pf16_ctl
  import pf16cvt_pkg::*;
#(
  parameter int MAX_LANES = 32
) (
  input  logic [1:0]           vlen_sel,
  input  logic                 src_is_mem,
  input  logic                 bcst_rc,
  input  logic [1:0]           rc_embedded,
  input  logic [1:0]           rc_global,
  input  logic [MAX_LANES-1:0] lane_mask,
  input  logic                 mask_en,
  output rnd_mode_e            rm_sel,
  output logic                 bcast_used,
  output logic [MAX_LANES-1:0] lane_in_len,
  output logic [MAX_LANES-1:0] lane_conv
);
  localparam int QTR  = MAX_LANES / 4;
  localparam int HALF = MAX_LANES / 2;

  logic emb_rc_used;

  assign emb_rc_used = ~src_is_mem & vlen_sel[1] & bcst_rc;
  assign rm_sel      = rnd_mode_e'(emb_rc_used ? rc_embedded : rc_global);
  assign bcast_used  = src_is_mem & bcst_rc;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane_ctl
    localparam bit IN_QTR  = (j < QTR);
    localparam bit IN_HALF = (j < HALF);
    assign lane_in_len[j] = vlen_sel[1] | (vlen_sel[0] ? IN_HALF : IN_QTR);
    assign lane_conv[j]   = lane_in_len[j] & (~mask_en | lane_mask[j]);
  end

endmodule

// File: rtl/pf16_lane.sv
module pf16_lane
  import pf16cvt_pkg::*;
(
  input  logic [HW-1:0] h_in,
  input  rnd_mode_e     rm,
  input  logic          in_len,
  input  logic          conv,
  input  logic          zero_mode,
  input  logic [HW-1:0] old_w,
  output logic [HW-1:0] w_out,
  output logic          inv_ev,
  output logic          inx_ev
);
  cvt_res_t res;

  assign res = fp16_to_u16(h_in, rm);

  always_comb begin
    if (!in_len)       w_out = '0;
    else if (conv)     w_out = res.val;
    else if (zero_mode) w_out = '0;
    else               w_out = old_w;
  end

  assign inv_ev = conv & res.inv;
  assign inx_ev = conv & res.inx;

endmodule

// File: rtl/pf16_u16_cvt.sv
module pf16_u16_cvt
  import pf16cvt_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter bit REG_OUT   = 1'b1,
  localparam int DW       = MAX_LANES * HW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           vlen_sel,
  input  logic [DW-1:0]        src_vec,
  input  logic                 src_is_mem,
  input  logic                 bcst_rc,
  input  logic [1:0]           rc_embedded,
  input  logic [1:0]           rc_global,
  input  logic [MAX_LANES-1:0] lane_mask,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  input  logic [DW-1:0]        old_dst,
  output logic                 out_valid,
  output logic [DW-1:0]        dst_vec,
  output logic                 flag_invalid,
  output logic                 flag_inexact
);
  rnd_mode_e            rm_sel;
  logic                 bcast_used;
  logic [MAX_LANES-1:0] lane_in_len;
  logic [MAX_LANES-1:0] lane_conv;
  logic [MAX_LANES-1:0] inv_vec;
  logic [MAX_LANES-1:0] inx_vec;
  logic [DW-1:0]        dst_comb;
  logic                 any_inv;
  logic                 any_inx;
  logic                 inv_q;
  logic                 inx_q;

  pf16_ctl #(.MAX_LANES(MAX_LANES)) u_ctl (
    .vlen_sel    (vlen_sel),
    .src_is_mem  (src_is_mem),
    .bcst_rc     (bcst_rc),
    .rc_embedded (rc_embedded),
    .rc_global   (rc_global),
    .lane_mask   (lane_mask),
    .mask_en     (mask_en),
    .rm_sel      (rm_sel),
    .bcast_used  (bcast_used),
    .lane_in_len (lane_in_len),
    .lane_conv   (lane_conv)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [HW-1:0] h_sel;
    assign h_sel = bcast_used ? src_vec[HW-1:0] : src_vec[j*HW +: HW];
    pf16_lane u_lane (
      .h_in      (h_sel),
      .rm        (rm_sel),
      .in_len    (lane_in_len[j]),
      .conv      (lane_conv[j]),
      .zero_mode (zero_mode),
      .old_w     (old_dst[j*HW +: HW]),
      .w_out     (dst_comb[j*HW +: HW]),
      .inv_ev    (inv_vec[j]),
      .inx_ev    (inx_vec[j])
    );
  end

  assign any_inv = |inv_vec;
  assign any_inx = |inx_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q <= 1'b0;
      inx_q <= 1'b0;
    end else if (in_valid) begin
      inv_q <= inv_q | any_inv;
      inx_q <= inx_q | any_inx;
    end
  end

  assign flag_invalid = inv_q;
  assign flag_inexact = inx_q;

  if (REG_OUT) begin : g_reg_out
    logic          vld_q;
    logic [DW-1:0] dst_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dst_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) dst_q <= dst_comb;
      end
    end
    assign out_valid = vld_q;
    assign dst_vec   = dst_q;
  end else begin : g_comb_out
    assign out_valid = in_valid;
    assign dst_vec   = dst_comb;
  end

endmodule

// File: rtl/pf16_u16_cvt_chk.sv
module pf16_u16_cvt_chk #(
  parameter int MAX_LANES = 32,
  parameter bit REG_OUT   = 1'b1,
  localparam int DW       = MAX_LANES * 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           vlen_sel,
  input logic [DW-1:0]        src_vec,
  input logic                 src_is_mem,
  input logic                 bcst_rc,
  input logic [MAX_LANES-1:0] lane_mask,
  input logic                 mask_en,
  input logic                 zero_mode,
  input logic [DW-1:0]        old_dst,
  input logic                 out_valid,
  input logic [DW-1:0]        dst_vec,
  input logic                 flag_invalid,
  input logic                 flag_inexact
);
  logic lane0_nan_bcast;
  assign lane0_nan_bcast = in_valid & src_is_mem & bcst_rc & (src_vec[14:10] == 5'h1f)
                         & (~mask_en | lane_mask[0]);

  // R10
  sticky_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);
  // R10
  sticky_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |=> flag_inexact);
  // R10
  masked_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && lane_mask == '0) |=> ($stable(flag_invalid) && $stable(flag_inexact)));

  if (REG_OUT) begin : g_lat1
    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dst_vec)));
    // R7
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen_sel == 2'b00) |=> (dst_vec[DW-1:DW/4] == '0));
    // R6
    merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen_sel[1] && mask_en && !zero_mode && lane_mask == '0)
        |=> (dst_vec == $past(old_dst)));
    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen_sel[1] && mask_en && zero_mode && lane_mask == '0)
        |=> (dst_vec == '0));
    // R8
    nan_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane0_nan_bcast |=> (flag_invalid && dst_vec[15:0] == 16'hFFFF));
  end

endmodule

bind pf16_u16_cvt pf16_u16_cvt_chk #(.MAX_LANES(MAX_LANES), .REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .vlen_sel     (vlen_sel),
  .src_vec      (src_vec),
  .src_is_mem   (src_is_mem),
  .bcst_rc      (bcst_rc),
  .lane_mask    (lane_mask),
  .mask_en      (mask_en),
  .zero_mode    (zero_mode),
  .old_dst      (old_dst),
  .out_valid    (out_valid),
  .dst_vec      (dst_vec),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact)
);

// File: tb/pf16_u16_cvt_bench.sv
`timescale 1ns/1ps
module pf16_u16_cvt_bench;
  localparam int NL = 32;
  localparam int DW = NL * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    vlen_sel = 2'b10;
  logic [DW-1:0] src_vec = '0;
  logic          src_is_mem = 1'b0;
  logic          bcst_rc = 1'b0;
  logic [1:0]    rc_embedded = 2'b00;
  logic [1:0]    rc_global = 2'b00;
  logic [NL-1:0] lane_mask = '0;
  logic          mask_en = 1'b0;
  logic          zero_mode = 1'b0;
  logic [DW-1:0] old_dst = '0;
  logic          out_valid;
  logic [DW-1:0] dst_vec;
  logic          flag_invalid;
  logic          flag_inexact;

  int  checks = 0;
  int  errors = 0;
  bit  exp_inv_st = 1'b0;
  bit  exp_inx_st = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  pf16_u16_cvt u_pf16_u16_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
    .src_vec(src_vec), .src_is_mem(src_is_mem), .bcst_rc(bcst_rc),
    .rc_embedded(rc_embedded), .rc_global(rc_global), .lane_mask(lane_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .old_dst(old_dst),
    .out_valid(out_valid), .dst_vec(dst_vec), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference conversion in real arithmetic
  function automatic logic [15:0] ref_cvt(input logic [15:0] h, input logic [1:0] rm,
                                          output bit inv, output bit inx);
    real v, fl, fr, r;
    int  e;
    inv = 1'b0;
    inx = 1'b0;
    e = int'(h[14:10]);
    if (e == 31) begin
      inv = 1'b1;
      return 16'hFFFF;
    end
    if (e == 0) v = (real'(h[9:0]) / 1024.0) * (2.0 ** (-14));
    else        v = (1.0 + real'(h[9:0]) / 1024.0) * (2.0 ** (e - 15));
    if (h[15]) v = -v;
    fl = $floor(v);
    fr = v - fl;
    case (rm)
      2'b00: begin
        if (fr > 0.5)      r = fl + 1.0;
        else if (fr < 0.5) r = fl;
        else               r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'b01: r = fl;
      2'b10: r = (fr > 0.0) ? fl + 1.0 : fl;
      default: r = (v < 0.0 && fr > 0.0) ? fl + 1.0 : fl;
    endcase
    if (r < 0.0 || r > 65535.0) begin
      inv = 1'b1;
      return 16'hFFFF;
    end
    inx = (fr != 0.0);
    return 16'($rtoi(r));
  endfunction

  task automatic model(output logic [DW-1:0] exp_dst, output bit inv_any, output bit inx_any);
    int nl;
    logic [1:0] rm;
    nl = (vlen_sel == 2'b00) ? 8 : (vlen_sel == 2'b01) ? 16 : 32;
    rm = (!src_is_mem && vlen_sel[1] && bcst_rc) ? rc_embedded : rc_global;
    exp_dst = '0;
    inv_any = 1'b0;
    inx_any = 1'b0;
    for (int j = 0; j < NL; j++) begin
      bit iv, ix;
      logic [15:0] h;
      if (j < nl) begin
        if (!mask_en || lane_mask[j]) begin
          h = (src_is_mem && bcst_rc) ? src_vec[15:0] : src_vec[j*16 +: 16];
          exp_dst[j*16 +: 16] = ref_cvt(h, rm, iv, ix);
          inv_any |= iv;
          inx_any |= ix;
        end else if (!zero_mode) begin
          exp_dst[j*16 +: 16] = old_dst[j*16 +: 16];
        end
      end
    end
  endtask

  // Drive current settings for one cycle, then compare one cycle later.
  task automatic do_op(input string tag);
    logic [DW-1:0] e_dst;
    bit ia, xa;
    model(e_dst, ia, xa);
    exp_inv_st |= ia;
    exp_inx_st |= xa;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && dst_vec === e_dst, tag, dst_vec, e_dst);
    chk(flag_invalid === exp_inv_st && flag_inexact === exp_inx_st,
        {tag, " flags R8 R9 R10"}, {510'd0, flag_invalid, flag_inexact},
        {510'd0, exp_inv_st, exp_inx_st});
  endtask

  task automatic rand_vec(output logic [DW-1:0] v);
    for (int j = 0; j < NL; j++) v[j*32 +: 32] = 32'($urandom) & 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] tmp;
    logic [DW-1:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(out_valid === 1'b0 && dst_vec === '0 && flag_invalid === 1'b0 && flag_inexact === 1'b0,
        "R12 reset", dst_vec, '0);

    // Exhaustive sweep of all half-precision codes under every rounding mode (R1 R2 R5 R6 R8 R9)
    for (int rm = 0; rm < 4; rm++) begin
      for (int b = 0; b < 2048; b++) begin
        for (int j = 0; j < NL; j++) src_vec[j*16 +: 16] = 16'(b * NL + j);
        vlen_sel    = 2'b10;
        bcst_rc     = 1'b0;
        src_is_mem  = 1'($urandom);
        rc_global   = 2'(rm);
        rc_embedded = ~2'(rm);
        mask_en     = 1'($urandom);
        lane_mask   = NL'($urandom);
        zero_mode   = 1'($urandom);
        rand_vec(tmp);
        old_dst     = tmp;
        do_op("R1 R2 R5 R6 sweep");
      end
    end

    // Fully random controls, including length and broadcast (R3 R4 R7)
    for (int i = 0; i < 600; i++) begin
      rand_vec(tmp);
      src_vec     = tmp;
      rand_vec(tmp);
      old_dst     = tmp;
      vlen_sel    = 2'($urandom);
      bcst_rc     = 1'($urandom);
      src_is_mem  = 1'($urandom);
      rc_global   = 2'($urandom);
      rc_embedded = 2'($urandom);
      mask_en     = 1'($urandom);
      lane_mask   = NL'($urandom);
      zero_mode   = 1'($urandom);
      do_op("R3 R4 R7 random");
    end

    // R3: embedded mode used for full-width register source with override bit; 2.5 -> 3 upward
    src_vec = {NL{16'h4100}};
    src_is_mem = 1'b0; bcst_rc = 1'b1; vlen_sel = 2'b10; mask_en = 1'b0;
    rc_global = 2'b00; rc_embedded = 2'b10;
    do_op("R3 embedded used");
    chk(dst_vec[15:0] === 16'd3, "R3 embedded lane0", {496'd0, dst_vec[15:0]}, 512'd3);
    // R3: half length -> global nearest-even gives 2
    vlen_sel = 2'b01;
    do_op("R3 global at half length");
    chk(dst_vec[15:0] === 16'd2, "R3 global lane0", {496'd0, dst_vec[15:0]}, 512'd2);

    // R4: broadcast element 0 (3.0) from memory source
    rand_vec(tmp);
    src_vec = tmp;
    src_vec[15:0] = 16'h4200;
    src_is_mem = 1'b1; bcst_rc = 1'b1; vlen_sel = 2'b10; rc_global = 2'b11;
    do_op("R4 broadcast");
    chk(dst_vec === {NL{16'd3}}, "R4 all lanes 3", dst_vec, {NL{16'd3}});

    // R7: quarter length clears upper bits even with all-ones old value
    old_dst = '1; src_is_mem = 1'b0; bcst_rc = 1'b0; vlen_sel = 2'b00;
    mask_en = 1'b1; lane_mask = '0; zero_mode = 1'b0;
    do_op("R7 quarter length");
    chk(dst_vec[DW-1:128] === '0 && dst_vec[127:0] === '1, "R7 upper clear", dst_vec,
        {384'd0, 128'h0 - 128'd1});

    // R9: -0.5 toward zero -> 0 with inexact
    src_vec = '0; src_vec[15:0] = 16'hB800;
    mask_en = 1'b1; lane_mask = 32'h1; zero_mode = 1'b1; rc_global = 2'b11;
    do_op("R9 negative to zero");
    chk(dst_vec === '0 && flag_inexact === 1'b1, "R9 neg zero", dst_vec, '0);

    // R2: smallest subnormal upward -> 1, nearest -> 0
    src_vec[15:0] = 16'h0001; rc_global = 2'b10;
    do_op("R2 subnormal up");
    chk(dst_vec[15:0] === 16'd1, "R2 subnormal up", {496'd0, dst_vec[15:0]}, 512'd1);

    // R8: -1.0 invalid
    src_vec[15:0] = 16'hBC00; rc_global = 2'b00;
    do_op("R8 negative one");
    chk(dst_vec[15:0] === 16'hFFFF && flag_invalid === 1'b1, "R8 neg invalid",
        {496'd0, dst_vec[15:0]}, {496'd0, 16'hFFFF});

    // R11: idle cycle keeps value and drops valid
    hold = dst_vec;
    @(negedge clk);
    chk(out_valid === 1'b0 && dst_vec === hold, "R11 idle hold", dst_vec, hold);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule